// File: doc/BRIEF.md
# Address-Request Rule Checker

This block watches the address channel of a memory-mapped bus port, either the write-address or the read-address side. On every cycle where `reqValid` and `reqReady` are both high, it checks the request fields against a fixed rule set. It then reports one flag per broken rule on the cycle that follows.

The rules cover four areas:
- **Bus limits:** transfer width and total burst size.
- **Burst types:** whether each burst type is allowed.
- **Regular profile:** a restricted profile with only power-of-two burst lengths, full-width beats and natural alignment.
- **Optional field dependencies:** atomic opcodes, memory-tag operations and cache-stash targets.

The block only observes. It never alters or stalls the request, and it does not look at the data channels. The rule profile is chosen at elaboration through parameters: data width, transaction byte limit, whether fixed bursts are disabled, and whether only regular transactions are allowed.

Top module: `axi_req_legality`

## Requirements
Burst codes are FIXED=0, INCR=1, WRAP=2 and 3=reserved. `violFlags` bit positions are listed next to each rule.

- R1: `violValid` is 1 for exactly the one cycle after a handshake (`reqValid`=1 and `reqReady`=1 at a rising edge). In every other cycle `violValid`=0 and `violFlags`=0, and a request held with `reqReady`=0 yields nothing.
- R2: Bit 0 is set when the beat width 2^`reqSize` bytes exceeds DATA_W/8.
- R3: Bit 1 is set when (`reqLen`+1)·2^`reqSize` exceeds MAX_TXN_BYTES.
- R4: Bit 2 is set for burst FIXED when FIXED_DISABLE=1 or REGULAR_ONLY=1. FIXED is legal when both are 0.
- R5: Bit 3 is set for the reserved burst code 3.
- R6: With REGULAR_ONLY=1, bit 4 is set when `reqLen` is not one of 0, 1, 3, 7, 15.
- R7: With REGULAR_ONLY=1, bit 5 is set when `reqLen`≠0 and 2^`reqSize` ≠ DATA_W/8.
- R8: With REGULAR_ONLY=1, bit 6 is set in two cases. For INCR with a permitted `reqLen`, it is set when the address is not a multiple of the total burst bytes. For WRAP, it is set when the address is not a multiple of 2^`reqSize`.
- R9: On a write, bit 7 is set when `reqAtomic`≠0 and `reqSize`>5.
- R10: When `reqTagOp`≠0, three bits can be set: bit 8 for a FIXED burst, bit 9 when `reqCache[3:0]`≠4'b0011, and bit 10 when `reqUniqueId`=0.
- R11: On a read (`reqIsRead`=1), bit 11 is set when `reqTagOp`=2. On a write, that value raises no bit 11.
- R12: On a write, bit 12 is set when `reqNodeStashEn`=0 and `reqNodeStashId`≠0. Bit 13 is set when `reqLpStashEn`=0 and `reqLpStashId`≠0.
- R13: On a read, the atomic and stash fields are ignored and raise none of bits 7, 12 or 13.
- R14: With REGULAR_ONLY=0, bits 4, 5 and 6 never rise, whatever the length, size or alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | input | 1 | Request ready |
| reqIsRead | input | 1 | 1 = read-address channel, 0 = write-address channel |
| reqAddr | input | ADDR_W | Start address |
| reqLen | input | 8 | Beats minus one |
| reqSize | input | 3 | log2 of beat bytes |
| reqBurst | input | 2 | Burst type code |
| reqCache | input | 4 | Cache attributes |
| reqAtomic | input | 6 | Atomic opcode, 0 = none |
| reqTagOp | input | 2 | Memory-tag operation, 0 = none |
| reqUniqueId | input | 1 | Unique-ID indicator |
| reqNodeStashEn | input | 1 | Stash node target enable |
| reqNodeStashId | input | 11 | Stash node target |
| reqLpStashEn | input | 1 | Stash logical-processor enable |
| reqLpStashId | input | 5 | Stash logical-processor target |
| violValid | output | 1 | Result strobe, one cycle after handshake |
| violFlags | output | 14 | One bit per broken rule |

## Verification
The hardest situations to reach are the ones where several rules overlap on one request. Examples are an over-long burst that also breaks the regular length set (where the alignment flag must stay quiet), and a tagged FIXED burst that trips the fixed-burst rule and three tag rules at once. The stimulus builds these field combinations by hand, each with its exact expected vector. Three instances with different profiles share the request fields but have separate valid lines, so the same request can be judged under regular, plain and fixed-disabled settings.

// File: rtl/axi_req_legality_pkg.sv
package axi_req_legality_pkg;
  localparam int NUM_RULES = 14;

  localparam int RULE_SIZE_WIDE   = 0;
  localparam int RULE_TOO_LONG    = 1;
  localparam int RULE_FIXED_OFF   = 2;
  localparam int RULE_BURST_RSVD  = 3;
  localparam int RULE_REG_LEN     = 4;
  localparam int RULE_REG_SIZE    = 5;
  localparam int RULE_REG_ALIGN   = 6;
  localparam int RULE_ATOM_SIZE   = 7;
  localparam int RULE_TAG_BURST   = 8;
  localparam int RULE_TAG_CACHE   = 9;
  localparam int RULE_TAG_UNIQ    = 10;
  localparam int RULE_TAG_RSVD    = 11;
  localparam int RULE_NODE_STASH  = 12;
  localparam int RULE_LP_STASH    = 13;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } chkStrobe_t;
endpackage

// File: rtl/axi_req_legality_ctrl.sv
module axi_req_legality_ctrl
  import axi_req_legality_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqReady,
  output chkStrobe_t strobe,
  output logic       violValid
);
  logic handshake;

  always_comb begin
    handshake     = reqValid && reqReady;
    strobe.capture = handshake;
    strobe.clear   = !handshake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) violValid <= 1'b0;
    else       violValid <= handshake;
  end
endmodule

// File: rtl/axi_req_legality_dp.sv
module axi_req_legality_dp
  import axi_req_legality_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 64,
  parameter int MAX_TXN_BYTES = 4096,
  parameter bit FIXED_DISABLE = 1'b0,
  parameter bit REGULAR_ONLY  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chkStrobe_t           strobe,
  input  logic                 reqIsRead,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [7:0]           reqLen,
  input  logic [2:0]           reqSize,
  input  logic [1:0]           reqBurst,
  input  logic [3:0]           reqCache,
  input  logic [5:0]           reqAtomic,
  input  logic [1:0]           reqTagOp,
  input  logic                 reqUniqueId,
  input  logic                 reqNodeStashEn,
  input  logic [10:0]          reqNodeStashId,
  input  logic                 reqLpStashEn,
  input  logic [4:0]           reqLpStashId,
  output logic [NUM_RULES-1:0] violFlags
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam int FULL_SIZE = $clog2(BUS_BYTES);
  localparam int SPAN_W    = 17;

  logic [SPAN_W-1:0] sizeBytes;
  logic [SPAN_W-1:0] totalBytes;
  logic [SPAN_W-1:0] addrLow;
  logic              isFixed;
  logic              isIncr;
  logic              isWrap;
  logic              tagActive;
  logic [2:0]        regVec;
  logic [NUM_RULES-1:0] ruleVec;

  always_comb begin
    sizeBytes  = SPAN_W'(1) << reqSize;
    totalBytes = (SPAN_W'(reqLen) + SPAN_W'(1)) << reqSize;
    addrLow    = SPAN_W'(reqAddr);
    isFixed    = (burst_e'(reqBurst) == BURST_FIXED);
    isIncr     = (burst_e'(reqBurst) == BURST_INCR);
    isWrap     = (burst_e'(reqBurst) == BURST_WRAP);
    tagActive  = (reqTagOp != 2'd0);
  end

  generate
    if (REGULAR_ONLY) begin : g_regular
      logic lenAllowed;
      always_comb begin
        lenAllowed = (reqLen == 8'd0) || (reqLen == 8'd1) || (reqLen == 8'd3) ||
                     (reqLen == 8'd7) || (reqLen == 8'd15);
        regVec[0]  = !lenAllowed;
        regVec[1]  = (reqLen != 8'd0) && (reqSize != 3'(FULL_SIZE));
        regVec[2]  = (isIncr && lenAllowed && ((addrLow & (totalBytes - SPAN_W'(1))) != '0)) ||
                     (isWrap && ((addrLow & (sizeBytes - SPAN_W'(1))) != '0));
      end
    end else begin : g_plain
      always_comb regVec = '0;
    end
  endgenerate

  always_comb begin
    ruleVec                  = '0;
    ruleVec[RULE_SIZE_WIDE]  = sizeBytes > SPAN_W'(BUS_BYTES);
    ruleVec[RULE_TOO_LONG]   = totalBytes > SPAN_W'(MAX_TXN_BYTES);
    ruleVec[RULE_FIXED_OFF]  = isFixed && (FIXED_DISABLE || REGULAR_ONLY);
    ruleVec[RULE_BURST_RSVD] = (burst_e'(reqBurst) == BURST_RSVD);
    ruleVec[RULE_REG_LEN]    = regVec[0];
    ruleVec[RULE_REG_SIZE]   = regVec[1];
    ruleVec[RULE_REG_ALIGN]  = regVec[2];
    ruleVec[RULE_ATOM_SIZE]  = !reqIsRead && (reqAtomic != 6'd0) && (reqSize > 3'd5);
    ruleVec[RULE_TAG_BURST]  = tagActive && isFixed;
    ruleVec[RULE_TAG_CACHE]  = tagActive && (reqCache != 4'b0011);
    ruleVec[RULE_TAG_UNIQ]   = tagActive && !reqUniqueId;
    ruleVec[RULE_TAG_RSVD]   = reqIsRead && (reqTagOp == 2'd2);
    ruleVec[RULE_NODE_STASH] = !reqIsRead && !reqNodeStashEn && (reqNodeStashId != 11'd0);
    ruleVec[RULE_LP_STASH]   = !reqIsRead && !reqLpStashEn && (reqLpStashId != 5'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              violFlags <= '0;
    else if (strobe.capture) violFlags <= ruleVec;
    else if (strobe.clear)   violFlags <= '0;
  end
endmodule

// File: rtl/axi_req_legality.sv
module axi_req_legality
  import axi_req_legality_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 64,
  parameter int MAX_TXN_BYTES = 4096,
  parameter bit FIXED_DISABLE = 1'b0,
  parameter bit REGULAR_ONLY  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqReady,
  input  logic               reqIsRead,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqLen,
  input  logic [2:0]         reqSize,
  input  logic [1:0]         reqBurst,
  input  logic [3:0]         reqCache,
  input  logic [5:0]         reqAtomic,
  input  logic [1:0]         reqTagOp,
  input  logic               reqUniqueId,
  input  logic               reqNodeStashEn,
  input  logic [10:0]        reqNodeStashId,
  input  logic               reqLpStashEn,
  input  logic [4:0]         reqLpStashId,
  output logic               violValid,
  output logic [13:0]        violFlags
);
  chkStrobe_t strobe;

  axi_req_legality_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .strobe    (strobe),
    .violValid (violValid)
  );

  axi_req_legality_dp #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .MAX_TXN_BYTES (MAX_TXN_BYTES),
    .FIXED_DISABLE (FIXED_DISABLE),
    .REGULAR_ONLY  (REGULAR_ONLY)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqIsRead      (reqIsRead),
    .reqAddr        (reqAddr),
    .reqLen         (reqLen),
    .reqSize        (reqSize),
    .reqBurst       (reqBurst),
    .reqCache       (reqCache),
    .reqAtomic      (reqAtomic),
    .reqTagOp       (reqTagOp),
    .reqUniqueId    (reqUniqueId),
    .reqNodeStashEn (reqNodeStashEn),
    .reqNodeStashId (reqNodeStashId),
    .reqLpStashEn   (reqLpStashEn),
    .reqLpStashId   (reqLpStashId),
    .violFlags      (violFlags)
  );
endmodule

// File: rtl/axi_req_legality_sva.sv
module axi_req_legality_sva #(
  parameter int DATA_W = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqIsRead,
  input logic [2:0]  reqSize,
  input logic [1:0]  reqBurst,
  input logic [1:0]  reqTagOp,
  input logic        violValid,
  input logic [13:0] violFlags
);
  localparam int FULL_SIZE = $clog2(DATA_W / 8);

  // R1: a handshake produces a result strobe on the next cycle
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> violValid);

  // R1: without a handshake the outputs are quiet on the next cycle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> (!violValid && violFlags == 14'd0));

  a_r2_size_wide: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSize > 3'(FULL_SIZE)) |=> violFlags[0]);

  a_r5_burst_rsvd: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqBurst == 2'd3) |=> violFlags[3]);

  a_r11_read_tag_rsvd: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIsRead && reqTagOp == 2'd2) |=> violFlags[11]);

  // R13: reads never raise the write-only atomic and stash flags
  a_r13_read_write_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIsRead) |=> (!violFlags[7] && !violFlags[12] && !violFlags[13]));
endmodule

bind axi_req_legality axi_req_legality_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqIsRead (reqIsRead),
  .reqSize   (reqSize),
  .reqBurst  (reqBurst),
  .reqTagOp  (reqTagOp),
  .violValid (violValid),
  .violFlags (violFlags)
);

// File: tb/axi_req_legality_bench.sv
module axi_req_legality_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  vSel = 3'b000;
  logic        reqReady = 1'b0;
  logic        reqIsRead = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqLen = '0;
  logic [2:0]  reqSize = '0;
  logic [1:0]  reqBurst = 2'd1;
  logic [3:0]  reqCache = '0;
  logic [5:0]  reqAtomic = '0;
  logic [1:0]  reqTagOp = '0;
  logic        reqUniqueId = 1'b0;
  logic        reqNodeStashEn = 1'b0;
  logic [10:0] reqNodeStashId = '0;
  logic        reqLpStashEn = 1'b0;
  logic [4:0]  reqLpStashId = '0;

  logic        vv0, vv1, vv2;
  logic [13:0] vf0, vf1, vf2;

  int checks = 0;
  int failures = 0;
  logic [13:0] expQ0[$];
  logic [13:0] expQ1[$];
  logic [13:0] expQ2[$];
  string tagQ0[$];
  string tagQ1[$];
  string tagQ2[$];

  always #2 clk = ~clk;  // 250 MHz

  // Regular-only profile, 64-bit data, 256-byte limit
  axi_req_legality #(.DATA_W(64), .MAX_TXN_BYTES(256), .FIXED_DISABLE(1'b0), .REGULAR_ONLY(1'b1))
  u_axi_req_legality (
    .clk(clk), .rstN(rstN), .reqValid(vSel[0]), .reqReady(reqReady), .reqIsRead(reqIsRead),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqBurst(reqBurst), .reqCache(reqCache),
    .reqAtomic(reqAtomic), .reqTagOp(reqTagOp), .reqUniqueId(reqUniqueId),
    .reqNodeStashEn(reqNodeStashEn), .reqNodeStashId(reqNodeStashId),
    .reqLpStashEn(reqLpStashEn), .reqLpStashId(reqLpStashId), .violValid(vv0), .violFlags(vf0));

  // Plain profile: no regular rules, fixed bursts allowed
  axi_req_legality #(.DATA_W(64), .MAX_TXN_BYTES(256), .FIXED_DISABLE(1'b0), .REGULAR_ONLY(1'b0))
  u_plain (
    .clk(clk), .rstN(rstN), .reqValid(vSel[1]), .reqReady(reqReady), .reqIsRead(reqIsRead),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqBurst(reqBurst), .reqCache(reqCache),
    .reqAtomic(reqAtomic), .reqTagOp(reqTagOp), .reqUniqueId(reqUniqueId),
    .reqNodeStashEn(reqNodeStashEn), .reqNodeStashId(reqNodeStashId),
    .reqLpStashEn(reqLpStashEn), .reqLpStashId(reqLpStashId), .violValid(vv1), .violFlags(vf1));

  // Fixed bursts disabled, regular rules off
  axi_req_legality #(.DATA_W(64), .MAX_TXN_BYTES(256), .FIXED_DISABLE(1'b1), .REGULAR_ONLY(1'b0))
  u_nofixed (
    .clk(clk), .rstN(rstN), .reqValid(vSel[2]), .reqReady(reqReady), .reqIsRead(reqIsRead),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqBurst(reqBurst), .reqCache(reqCache),
    .reqAtomic(reqAtomic), .reqTagOp(reqTagOp), .reqUniqueId(reqUniqueId),
    .reqNodeStashEn(reqNodeStashEn), .reqNodeStashId(reqNodeStashId),
    .reqLpStashEn(reqLpStashEn), .reqLpStashId(reqLpStashId), .violValid(vv2), .violFlags(vf2));

  task automatic compare(input logic [13:0] act, input logic [13:0] exp, input string req, input int inst);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s inst%0d actual=%04h expected=%04h", req, inst, act, exp);
    end
  endtask

  // Monitor: pops expected results as the instances produce them
  always @(negedge clk) begin
    if (rstN) begin
      if (vv0) begin
        if (expQ0.size() == 0) compare(vf0, 14'h3fff, "R1 unexpected result", 0);
        else compare(vf0, expQ0.pop_front(), tagQ0.pop_front(), 0);
      end
      if (vv1) begin
        if (expQ1.size() == 0) compare(vf1, 14'h3fff, "R1 unexpected result", 1);
        else compare(vf1, expQ1.pop_front(), tagQ1.pop_front(), 1);
      end
      if (vv2) begin
        if (expQ2.size() == 0) compare(vf2, 14'h3fff, "R1 unexpected result", 2);
        else compare(vf2, expQ2.pop_front(), tagQ2.pop_front(), 2);
      end
    end
  end

  // Driver: applies one request to one instance and queues its expected flags
  task automatic drive(input int sel, input logic rd, input logic [31:0] addr, input logic [7:0] len,
                       input logic [2:0] size, input logic [1:0] burst, input logic [3:0] cache,
                       input logic [5:0] atop, input logic [1:0] tag, input logic uniq,
                       input logic nEn, input logic [10:0] nId, input logic lEn, input logic [4:0] lId,
                       input logic [13:0] exp, input string req);
    @(negedge clk);
    reqIsRead = rd; reqAddr = addr; reqLen = len; reqSize = size; reqBurst = burst;
    reqCache = cache; reqAtomic = atop; reqTagOp = tag; reqUniqueId = uniq;
    reqNodeStashEn = nEn; reqNodeStashId = nId; reqLpStashEn = lEn; reqLpStashId = lId;
    reqReady = 1'b1;
    vSel = 3'b000;
    vSel[sel] = 1'b1;
    case (sel)
      0: begin expQ0.push_back(exp); tagQ0.push_back(req); end
      1: begin expQ1.push_back(exp); tagQ1.push_back(req); end
      default: begin expQ2.push_back(exp); tagQ2.push_back(req); end
    endcase
    @(negedge clk);
    vSel = 3'b000;
    reqReady = 1'b0;
  endtask

  initial begin
    #(4 * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare({vv2, vv1, vv0, 11'd0}, 14'd0, "R1 reset valid", 0);
    compare(vf0 | vf1 | vf2, 14'd0, "R1 reset flags", 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: held request without ready produces nothing
    vSel = 3'b111; reqReady = 1'b0; reqBurst = 2'd3;
    @(negedge clk);
    @(negedge clk);
    compare({vv2, vv1, vv0, 11'd0}, 14'd0, "R1 no handshake valid", 0);
    compare(vf0, 14'd0, "R1 no handshake flags", 0);
    vSel = 3'b000;

    // sel rd addr len sz bu cache atop tag u nEn nId lEn lId exp
    drive(0, 0, 32'h100, 8'd3, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R1 clean request");
    drive(0, 0, 32'h0,   8'd0, 3'd4, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0001, "R2 size wider than bus");
    drive(0, 0, 32'h0,   8'd63, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0012, "R3 R6 too long and bad length");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd0, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0004, "R4 fixed in regular mode");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd3, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0008, "R5 reserved burst");
    drive(0, 0, 32'h0,   8'd1, 3'd2, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0020, "R7 narrow regular burst");
    drive(0, 0, 32'h8,   8'd3, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0040, "R8 INCR misaligned");
    drive(0, 0, 32'h8,   8'd3, 3'd3, 2'd2, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R8 WRAP beat aligned");
    drive(0, 1, 32'h4,   8'd3, 3'd3, 2'd2, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0040, "R8 WRAP misaligned");
    drive(0, 0, 32'h0,   8'd0, 3'd6, 2'd1, 4'd0, 6'd1, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0081, "R9 atomic size");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd1, 4'd0, 6'd1, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R9 atomic legal size");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd0, 4'd0, 6'd0, 2'd1, 0, 0, 11'd0, 0, 5'd0, 14'h0704, "R10 tag on fixed");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd1, 4'd3, 6'd0, 2'd1, 1, 0, 11'd0, 0, 5'd0, 14'h0000, "R10 tag legal");
    drive(0, 1, 32'h0,   8'd0, 3'd3, 2'd1, 4'd3, 6'd0, 2'd2, 1, 0, 11'd0, 0, 5'd0, 14'h0800, "R11 read tag reserved");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd1, 4'd3, 6'd0, 2'd2, 1, 0, 11'd0, 0, 5'd0, 14'h0000, "R11 write tag value 2");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd5, 0, 5'd3, 14'h3000, "R12 stash without enable");
    drive(0, 0, 32'h0,   8'd0, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 1, 11'd5, 1, 5'd3, 14'h0000, "R12 stash enabled");
    drive(0, 1, 32'h0,   8'd0, 3'd6, 2'd1, 4'd0, 6'd1, 2'd0, 0, 0, 11'd5, 0, 5'd3, 14'h0001, "R13 read ignores atomic and stash");
    drive(1, 0, 32'h3,   8'd5, 3'd2, 2'd0, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R14 R4 plain fixed legal");
    drive(1, 0, 32'h1,   8'd5, 3'd1, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R14 no regular rules");
    drive(1, 0, 32'h0,   8'd0, 3'd4, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0001, "R2 plain size");
    drive(2, 0, 32'h0,   8'd0, 3'd3, 2'd0, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0004, "R4 fixed disabled");
    drive(2, 0, 32'h0,   8'd31, 3'd3, 2'd1, 4'd0, 6'd0, 2'd0, 0, 0, 11'd0, 0, 5'd0, 14'h0000, "R3 exactly at limit");

    // R1: idle cycle after results returns to zero
    @(negedge clk);
    compare({vv2, vv1, vv0, 11'd0}, 14'd0, "R1 idle after result", 0);
    compare(vf0 | vf1 | vf2, 14'd0, "R1 idle flags", 0);
    checks++;
    if (expQ0.size() + expQ1.size() + expQ2.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results actual=%0d expected=0",
               expQ0.size() + expQ1.size() + expQ2.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule